// File: doc/BRIEF.md
# Multiplexed-Address Burst Write Slave

This block is a synchronous slave port on the host side. It accepts sequential burst writes over one bus that carries both address and data. While chip select is low, the host pulses an address-latch input. On that edge the block takes the starting address from the bus, together with a memory/register select bit and a read/write bit. On the next clock the host gives a one-cycle active-low strobe, and the burst begins. The block drives its active-low ready output low for one lead cycle. After that it takes one 16-bit word per clock into an internal array and steps the address by one after each word.

The host holds the active-low last input high for every word except the final one. The final word is captured on the edge where last is sampled low, and ready returns high on that same edge. Chip select must stay low until then. If it rises earlier, the burst is aborted. Both word-enable bits must be high for each word. Any other value blocks that word's write and raises an access-error flag. An active-low stop output follows a command-queue-full input. A combinational peek port reads the array so that its contents can be observed.

Top module: `mux_burst_wr_slave`

## Requirements
- R1: After a synchronous reset, readyN is 1, accessErr is 0, and no array write happens until a new burst is started.
- R2: With selN low and addrLatch sampled high on a clock edge, the low ADDR_W bits of busData become the burst start address. memSel (1 = memory) and rdWr (1 = read, 0 = write) are captured on the same edge.
- R3: If strobeN is sampled low with selN low on the edge right after the address latch, readyN is 0 after that edge.
- R4: readyN stays low for one lead cycle before any word is taken. The first word is the bus value on the second edge after the strobe edge, and it is written at the start address.
- R5: From then on, one word is taken on every edge while readyN is low. The address increments by one, modulo 2^ADDR_W, after each word.
- R6: The word on the edge where lastN is sampled low is the final one. readyN is 1 after that edge, and no further words are written.
- R7: If selN is sampled high during a burst, nothing is written on that edge, readyN is 1 after it, and the port is idle.
- R8: A word whose wordEn is not 2'b11 is not written, but the address still advances. accessErr becomes 1 after that edge and stays 1 until the next address latch.
- R9: Array writes happen only when the latched memSel is 1 and the latched rdWr is 0. Any other latched mode completes the handshake without writing.
- R10: stopN equals the inverse of queueFull in every cycle, including during a burst.
- R11: If strobeN is not low on the edge after the address latch, and addrLatch is not high again on that edge, the port returns to idle and readyN stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| selN | input | 1 | Chip select, active low |
| addrLatch | input | 1 | Address latch pulse, active high |
| strobeN | input | 1 | Burst start strobe, active low |
| memSel | input | 1 | 1 = memory space, captured at latch |
| rdWr | input | 1 | 1 = read, 0 = write, captured at latch |
| wordEn | input | 2 | Word enables, must be 2'b11 |
| lastN | input | 1 | Final-word marker, active low |
| busData | input | 16 | Shared address/data bus |
| queueFull | input | 1 | Command queue full indication |
| readyN | output | 1 | Ready, active low |
| stopN | output | 1 | Stop, active low |
| accessErr | output | 1 | Word-enable error flag |
| wrStrobe | output | 1 | High in cycles whose edge writes the array |
| peekAddr | input | 8 | Observation read address |
| peekData | output | 16 | Array content at peekAddr |

## Verification
The final word can carry a word-enable error, so completion and the write block fall on the same edge. The bench also raises queueFull in the same cycle as a last-word capture. It provokes both across sweeps of start address (including wrap past the top of the array), burst length and error position. It then compares every array location, readyN, accessErr and stopN against a shadow model that the bench updates arithmetically.

// File: rtl/mbws_pkg.sv
package mbws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_LATCHED,
    ST_READY_LEAD,
    ST_BURST,
    ST_DONE
  } mbwsState_t;

  typedef struct packed {
    logic loadAddr;
    logic advance;
    logic writeWord;
    logic flagErr;
  } mbwsStrobes_t;
endpackage

// File: rtl/mbws_ctrl.sv
module mbws_ctrl
  import mbws_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         selN,
  input  logic         addrLatch,
  input  logic         strobeN,
  input  logic         lastN,
  input  logic [1:0]   wordEn,
  input  logic         modeWrite,
  output mbwsStrobes_t strb,
  output logic         readyN
);
  mbwsState_t state, nextState;
  logic inBurst;
  logic wordOk;

  always_comb begin
    nextState = state;
    if (selN) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:         if (addrLatch) nextState = ST_ADDR_LATCHED;
        ST_ADDR_LATCHED: begin
          if (!strobeN)       nextState = ST_READY_LEAD;
          else if (addrLatch) nextState = ST_ADDR_LATCHED;
          else                nextState = ST_IDLE;
        end
        ST_READY_LEAD:   nextState = ST_BURST;
        ST_BURST:        if (!lastN) nextState = ST_DONE;
        ST_DONE:         nextState = ST_DONE;
        default:         nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign inBurst = (state == ST_BURST) && !selN;
  assign wordOk  = (wordEn == 2'b11);

  always_comb begin
    strb.loadAddr  = !selN && addrLatch &&
                     ((state == ST_IDLE) || ((state == ST_ADDR_LATCHED) && strobeN));
    strb.advance   = inBurst;
    strb.writeWord = inBurst && wordOk && modeWrite;
    strb.flagErr   = inBurst && !wordOk;
  end

  assign readyN = !((state == ST_READY_LEAD) || (state == ST_BURST));

  assert_strobe_start_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_LATCHED && !strobeN && !selN) |=> (!readyN && state == ST_READY_LEAD));

  assert_lead_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READY_LEAD && !selN) |=> (state == ST_BURST && !readyN));

  assert_last_word_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BURST && !lastN && !selN) |=> (readyN && !strb.writeWord));

  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    selN |=> (state == ST_IDLE && readyN));

  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_LATCHED && strobeN && !addrLatch && !selN) |=> (state == ST_IDLE));
endmodule

// File: rtl/mbws_datapath.sv
module mbws_datapath
  import mbws_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mbwsStrobes_t      strb,
  input  logic              memSel,
  input  logic              rdWr,
  input  logic [DATA_W-1:0] busData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic              modeWrite,
  output logic              accessErr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] curAddr;
  logic              modeMem;
  logic              modeRd;
  logic [DATA_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr   <= '0;
      modeMem   <= 1'b0;
      modeRd    <= 1'b1;
      accessErr <= 1'b0;
    end else begin
      if (strb.loadAddr) begin
        curAddr   <= busData[ADDR_W-1:0];
        modeMem   <= memSel;
        modeRd    <= rdWr;
        accessErr <= 1'b0;
      end else begin
        if (strb.advance) curAddr <= curAddr + 1'b1;
        if (strb.flagErr) accessErr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeWord) memArr[curAddr] <= busData;
  end

  assign modeWrite = modeMem && !modeRd;
  assign peekData  = memArr[peekAddr];

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
    strb.loadAddr |=> (curAddr == $past(busData[ADDR_W-1:0])));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    strb.advance |=> (curAddr == ADDR_W'($past(curAddr) + 1'b1)));

  assert_err_flag_R8: assert property (@(posedge clk) disable iff (rst)
    strb.flagErr |=> accessErr);

  assert_mode_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (strb.writeWord && !strb.loadAddr) |-> (modeMem && !modeRd));
endmodule

// File: rtl/mux_burst_wr_slave.sv
module mux_burst_wr_slave
  import mbws_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selN,
  input  logic              addrLatch,
  input  logic              strobeN,
  input  logic              memSel,
  input  logic              rdWr,
  input  logic [1:0]        wordEn,
  input  logic              lastN,
  input  logic [DATA_W-1:0] busData,
  input  logic              queueFull,
  output logic              readyN,
  output logic              stopN,
  output logic              accessErr,
  output logic              wrStrobe,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData
);
  mbwsStrobes_t strb;
  logic         modeWrite;

  mbws_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .selN     (selN),
    .addrLatch(addrLatch),
    .strobeN  (strobeN),
    .lastN    (lastN),
    .wordEn   (wordEn),
    .modeWrite(modeWrite),
    .strb     (strb),
    .readyN   (readyN)
  );

  mbws_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .memSel   (memSel),
    .rdWr     (rdWr),
    .busData  (busData),
    .peekAddr (peekAddr),
    .peekData (peekData),
    .modeWrite(modeWrite),
    .accessErr(accessErr)
  );

  assign stopN    = !queueFull;
  assign wrStrobe = strb.writeWord;

  assert_write_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |-> (!readyN && !selN));
endmodule

// File: tb/sim_mux_burst_wr_slave.sv
module sim_mux_burst_wr_slave;
  logic        clk = 1'b0;
  logic        rst;
  logic        selN, addrLatch, strobeN, memSel, rdWr, lastN, queueFull;
  logic [1:0]  wordEn;
  logic [15:0] busData;
  logic        readyN, stopN, accessErr, wrStrobe;
  logic [7:0]  peekAddr;
  logic [15:0] peekData;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [256];

  always #5 clk = ~clk;

  mux_burst_wr_slave u0 (
    .clk(clk), .rst(rst), .selN(selN), .addrLatch(addrLatch), .strobeN(strobeN),
    .memSel(memSel), .rdWr(rdWr), .wordEn(wordEn), .lastN(lastN), .busData(busData),
    .queueFull(queueFull), .readyN(readyN), .stopN(stopN), .accessErr(accessErr),
    .wrStrobe(wrStrobe), .peekAddr(peekAddr), .peekData(peekData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleBus();
    selN = 1'b1; addrLatch = 1'b0; strobeN = 1'b1; lastN = 1'b1;
    wordEn = 2'b11; busData = '0;
  endtask

  task automatic compareMem(input string req);
    int bad = 0;
    for (int a = 0; a < 256; a++) begin
      peekAddr = a[7:0];
      #1;
      if (peekData !== model[a]) begin
        if (bad == 0) chk(req, {a[15:0], peekData}, {a[15:0], model[a]});
        bad++;
      end
    end
    if (bad == 0) chk(req, 0, 0);
  endtask

  function automatic logic [15:0] wordVal(input int tag, input int idx);
    return 16'((tag * 16'h1357) ^ (idx * 16'h0101) ^ 16'hA5C3);
  endfunction

  // errMask bit i: word i uses wordEn=badEn. abortAt>=0: selN high instead of word abortAt.
  task automatic burst(input int start, input int n, input int tag, input logic ms,
                       input logic rw, input int errMask, input logic [1:0] badEn,
                       input int abortAt, input logic qfLast);
    logic anyErr = 1'b0;
    @(negedge clk);
    selN = 1'b0; addrLatch = 1'b1; memSel = ms; rdWr = rw;
    busData = 16'(start) | 16'hFF00;
    @(negedge clk);
    addrLatch = 1'b0; strobeN = 1'b0; busData = 16'hDEAD;
    @(negedge clk);
    strobeN = 1'b1;
    chk("R3 ready low after strobe", readyN, 0);
    @(negedge clk);
    chk("R4 ready held through lead", readyN, 0);
    for (int i = 0; i < n; i++) begin
      if (i == abortAt) begin
        selN = 1'b1; busData = 16'hBAD0;
        @(negedge clk);
        chk("R7 abort ready high", readyN, 1);
        break;
      end
      busData = wordVal(tag, i);
      lastN = (i == n - 1) ? 1'b0 : 1'b1;
      wordEn = errMask[i] ? badEn : 2'b11;
      queueFull = (i == n - 1) ? qfLast : 1'b0;
      #1;
      chk("R10 stop follows queue", stopN, !queueFull);
      if (errMask[i]) anyErr = 1'b1;
      else if (ms && !rw) model[(start + i) % 256] = wordVal(tag, i);
      @(negedge clk);
    end
    if (abortAt < 0) begin
      chk("R6 ready high after last", readyN, 1);
      chk("R8 access error flag", accessErr, anyErr);
      // stay selected one more cycle: nothing more must be written
      busData = 16'hBEEF; lastN = 1'b1; wordEn = 2'b11; queueFull = 1'b0;
      @(negedge clk);
      chk("R6 idle after done", readyN, 1);
    end
    idleBus();
    queueFull = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idleBus();
    memSel = 1'b1; rdWr = 1'b0; queueFull = 1'b0; peekAddr = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", readyN, 1);
    chk("R1 reset error flag", accessErr, 0);
    chk("R1 reset no write", wrStrobe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", readyN, 1);

    // fill whole array with one 256-word burst from address 0
    burst(0, 256, 1, 1'b1, 1'b0, 0, 2'b00, -1, 1'b0);
    compareMem("R2 R5 full fill");

    // sweep lengths and start addresses, including wrap
    for (int s = 0; s < 4; s++) begin
      for (int n = 1; n <= 6; n++) begin
        int st = (s == 3) ? 254 : s * 37 + 5;
        burst(st, n, 10 + s * 8 + n, 1'b1, 1'b0, 0, 2'b00, -1, 1'b0);
      end
      compareMem("R4 R5 length sweep");
    end

    // word-enable errors at every position, incl. last, with queueFull on last word
    for (int p = 0; p < 4; p++) begin
      logic [1:0] be = (p % 3 == 0) ? 2'b01 : ((p % 3 == 1) ? 2'b10 : 2'b00);
      burst(100 + p * 8, 4, 60 + p, 1'b1, 1'b0, 1 << p, be, -1, 1'b1);
      compareMem("R8 word enable block");
    end
    burst(140, 3, 70, 1'b1, 1'b0, 0, 2'b00, -1, 1'b0);
    chk("R8 error cleared by new latch", accessErr, 0);

    // register space and read mode: no writes
    burst(20, 5, 80, 1'b0, 1'b0, 0, 2'b00, -1, 1'b0);
    compareMem("R9 register space no write");
    burst(30, 5, 81, 1'b1, 1'b1, 0, 2'b00, -1, 1'b0);
    compareMem("R9 read mode no write");

    // abort mid-burst
    for (int k = 0; k < 3; k++) begin
      burst(200, 6, 90 + k, 1'b1, 1'b0, 0, 2'b00, k + 1, 1'b0);
      compareMem("R7 abort stops writes");
    end
    burst(210, 2, 95, 1'b1, 1'b0, 0, 2'b00, -1, 1'b0);
    compareMem("R7 burst after abort");

    // latch without strobe
    @(negedge clk);
    selN = 1'b0; addrLatch = 1'b1; busData = 16'd50;
    @(negedge clk);
    addrLatch = 1'b0; busData = 16'h1111;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R11 no strobe ready high", readyN, 1);
      chk("R11 no strobe no write", wrStrobe, 0);
    end
    idleBus();
    @(negedge clk);
    compareMem("R11 memory unchanged");

    // stop output outside bursts
    queueFull = 1'b1; #1;
    chk("R10 stop low on full", stopN, 0);
    queueFull = 1'b0; #1;
    chk("R10 stop high when not full", stopN, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule